// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control for a three-phase integrating converter. It runs from the oscillator clock and divides it down into counts. It steps the analog front end through auto-zero, signal integrate and reference integrate by driving three one-hot phase outputs. It chooses the polarity of the reference used to ramp the integrator back. A single comparator input reports which side of zero the integrator output sits on, with high meaning the positive side.

When signal integrate ends, the block samples the comparator to learn the sign of the input. It then counts reference-integrate counts until the comparator flips. That count is the reading, and it is kept as four BCD decades. Auto-zero takes up whatever reference-integrate time was not used, so the distance between the starts of consecutive signal-integrate phases is always one fixed frame of counts, whatever the input.

Each finished reading is copied into an output latch together with a minus flag and an overrange flag, and a one-clock valid strobe marks the update.

Top module: `dsadc_seq`

## Requirements
- R1: One count lasts exactly CLK_DIV clocks. Every phase occupies a whole number of counts, so each phase output stays high for a multiple of CLK_DIV clocks.
- R2: Exactly one of `az_o`, `si_o`, `ri_o` is high in every cycle. Phases always follow the order auto-zero, signal integrate, reference integrate, then auto-zero again.
- R3: Signal integrate lasts exactly SI_COUNTS counts, for any comparator input.
- R4: Reference integrate ends on the first count at which the sampled comparator level equals `ref_neg_o`, which is the zero-crossing. Its duration is the reading plus one count. If no crossing occurs, it lasts RI_MAX counts.
- R5: After a completed reference integrate of D counts, auto-zero lasts FRAME_COUNTS - SI_COUNTS - D counts. Signal-integrate starts are therefore FRAME_COUNTS counts apart.
- R6: The comparator is sampled on the last signal-integrate count. A low level (negative input) makes `ref_neg_o` high for the whole following reference integrate, and `rd_neg_o` of that reading equals `ref_neg_o`.
- R7: `rd_bcd_o` holds the number of counts spent in reference integrate before the crossing count. It is four BCD digits: bits [15:12] thousands, [11:8] hundreds, [7:4] tens, [3:0] units.
- R8: `rd_bcd_o`, `rd_neg_o` and `rd_over_o` change only in a cycle where `rd_valid_o` is high. `rd_valid_o` is high for exactly one clock, the first clock after `ri_o` falls.
- R9: While `rst` is high, the block drives `az_o`=1, `si_o`=`ri_o`=0, `ref_neg_o`=0, all latched outputs 0 and `rd_valid_o`=0. The first auto-zero after reset lasts FRAME_COUNTS - SI_COUNTS - RI_MAX counts.
- R10: If no crossing occurs within RI_MAX counts, the reading is latched with `rd_over_o`=1 and `rd_bcd_o` saturated at RI_MAX-1 in BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparator: 1 when the integrator output is on the positive side |
| az_o | output | 1 | Auto-zero phase select |
| si_o | output | 1 | Signal-integrate phase select |
| ri_o | output | 1 | Reference-integrate phase select |
| ref_neg_o | output | 1 | Selects the reference polarity for a negative input |
| rd_bcd_o | output | 16 | Latched reading, four BCD digits |
| rd_neg_o | output | 1 | Latched minus flag |
| rd_over_o | output | 1 | Latched overrange flag |
| rd_valid_o | output | 1 | One-clock strobe on each latch update |

## Verification
The bench places the comparator crossing at a zero reading, at a one-count reading, at a reading with a carry into the thousands digit, and at 1999. It also runs conversions that never cross, for both signs. An off-by-one in the crossing test would show up as a reading one too high and a reference phase one count long. A design that forgot to hand unused reference time to auto-zero would break the fixed frame and fail the auto-zero length check. Wrong saturation would latch 2000 or wrap around instead of 1999 with the overrange flag. A reset applied in the middle of signal integrate must restart the shortest auto-zero; a design that kept its old counters would start signal integrate at the wrong clock.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  localparam int DIGITS = 4;
  typedef enum logic [1:0] {PH_AZ = 2'd0, PH_SI = 2'd1, PH_RI = 2'd2} phase_e;
endpackage

// File: rtl/dsadc_prescale.sv
module dsadc_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  generate
    if (DIV == 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/dsadc_bcd_count.sv
module dsadc_bcd_count #(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [4*DIGITS-1:0]   q_o
);
  logic [DIGITS-1:0] carry;
  assign carry[0] = inc_i;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_dec
      logic [3:0] dig_q;
      always_ff @(posedge clk) begin
        if (rst || clr_i)  dig_q <= 4'd0;
        else if (carry[d]) dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
      end
      assign q_o[4*d +: 4] = dig_q;
      if (d < DIGITS - 1) begin : g_carry
        assign carry[d+1] = carry[d] && (dig_q == 4'd9);
      end
    end
  endgenerate
endmodule

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int SI_COUNTS    = 1000,
  parameter int RI_MAX       = 2000,
  parameter int FRAME_COUNTS = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic cmp_i,
  output logic az_o,
  output logic si_o,
  output logic ri_o,
  output logic neg_o,
  output logic clr_o,
  output logic inc_o,
  output logic end_o,
  output logic over_o
);
  localparam int CW = $clog2(FRAME_COUNTS + 1);
  localparam logic [CW-1:0] AZ_MIN  = CW'(FRAME_COUNTS - SI_COUNTS - RI_MAX);
  localparam logic [CW-1:0] AZ_BASE = CW'(FRAME_COUNTS - SI_COUNTS - 1);
  localparam logic [CW-1:0] SI_LAST = CW'(SI_COUNTS - 1);
  localparam logic [CW-1:0] RI_LAST = CW'(RI_MAX - 1);

  phase_e        ph_q;
  logic [CW-1:0] pcnt_q;
  logic [CW-1:0] az_len_q;
  logic          neg_q;

  logic crossed, last_az, last_si, last_ri;
  assign crossed = (cmp_i == neg_q);
  assign last_az = (pcnt_q == az_len_q - CW'(1));
  assign last_si = (pcnt_q == SI_LAST);
  assign last_ri = crossed || (pcnt_q == RI_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_AZ;
      pcnt_q   <= '0;
      az_len_q <= AZ_MIN;
      neg_q    <= 1'b0;
      az_o     <= 1'b1;
      si_o     <= 1'b0;
      ri_o     <= 1'b0;
    end else if (tick_i) begin
      unique case (ph_q)
        PH_AZ: begin
          if (last_az) begin
            ph_q   <= PH_SI;
            pcnt_q <= '0;
            az_o   <= 1'b0;
            si_o   <= 1'b1;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        PH_SI: begin
          if (last_si) begin
            ph_q   <= PH_RI;
            pcnt_q <= '0;
            neg_q  <= ~cmp_i;
            si_o   <= 1'b0;
            ri_o   <= 1'b1;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        default: begin
          if (last_ri) begin
            ph_q     <= PH_AZ;
            pcnt_q   <= '0;
            az_len_q <= AZ_BASE - pcnt_q;
            ri_o     <= 1'b0;
            az_o     <= 1'b1;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign neg_o  = neg_q;
  assign clr_o  = tick_i && (ph_q == PH_SI) && last_si;
  assign inc_o  = tick_i && (ph_q == PH_RI) && !last_ri;
  assign end_o  = tick_i && (ph_q == PH_RI) && last_ri;
  assign over_o = !crossed;
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int SI_COUNTS    = 1000,
  parameter int RI_MAX       = 2000,
  parameter int FRAME_COUNTS = 4000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmp_i,
  output logic                az_o,
  output logic                si_o,
  output logic                ri_o,
  output logic                ref_neg_o,
  output logic [4*DIGITS-1:0] rd_bcd_o,
  output logic                rd_neg_o,
  output logic                rd_over_o,
  output logic                rd_valid_o
);
  logic tick, clr, inc, done, over;
  logic [4*DIGITS-1:0] count;

  dsadc_prescale #(.DIV(CLK_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  dsadc_phase_ctrl #(
    .SI_COUNTS(SI_COUNTS), .RI_MAX(RI_MAX), .FRAME_COUNTS(FRAME_COUNTS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick_i(tick), .cmp_i(cmp_i),
    .az_o(az_o), .si_o(si_o), .ri_o(ri_o), .neg_o(ref_neg_o),
    .clr_o(clr), .inc_o(inc), .end_o(done), .over_o(over)
  );

  dsadc_bcd_count #(.DIGITS(DIGITS)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(clr), .inc_i(inc), .q_o(count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bcd_o   <= '0;
      rd_neg_o   <= 1'b0;
      rd_over_o  <= 1'b0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= done;
      if (done) begin
        rd_bcd_o  <= count;
        rd_neg_o  <= ref_neg_o;
        rd_over_o <= over;
      end
    end
  end
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int RI_MAX = 2000
) (
  input logic        clk,
  input logic        rst,
  input logic        az_o,
  input logic        si_o,
  input logic        ri_o,
  input logic        ref_neg_o,
  input logic [15:0] rd_bcd_o,
  input logic        rd_neg_o,
  input logic        rd_over_o,
  input logic        rd_valid_o
);
  function automatic logic [15:0] to_bcd(int v);
    logic [15:0] r;
    int x;
    x = v;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  localparam logic [15:0] SAT = to_bcd(RI_MAX - 1);

  p_one_phase_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({az_o, si_o, ri_o}) == 1);
  p_si_after_az_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(si_o) |-> $past(az_o));
  p_ri_after_si_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ri_o) |-> $past(si_o));
  p_az_after_ri_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(az_o) |-> $past(ri_o));
  p_ref_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (ri_o && $past(ri_o)) |-> $stable(ref_neg_o));
  p_minus_match_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> (rd_neg_o == ref_neg_o));
  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |=> !rd_valid_o);
  p_valid_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ri_o) |-> rd_valid_o);
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable({rd_bcd_o, rd_neg_o, rd_over_o}) |-> rd_valid_o);
  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (az_o && !si_o && !ri_o && !rd_valid_o));
  p_over_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && rd_over_o) |-> (rd_bcd_o == SAT));
endmodule

bind dsadc_seq dsadc_seq_chk #(.RI_MAX(RI_MAX)) u_chk (
  .clk(clk), .rst(rst), .az_o(az_o), .si_o(si_o), .ri_o(ri_o),
  .ref_neg_o(ref_neg_o), .rd_bcd_o(rd_bcd_o), .rd_neg_o(rd_neg_o),
  .rd_over_o(rd_over_o), .rd_valid_o(rd_valid_o)
);

// File: tb/dsadc_seq_test.sv
module dsadc_seq_test;
  localparam int DIV   = 2;
  localparam int SI    = 1000;
  localparam int RIMAX = 2000;
  localparam int FRAME = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp = 1'b1;
  logic az_o, si_o, ri_o, ref_neg_o, rd_neg_o, rd_over_o, rd_valid_o;
  logic [15:0] rd_bcd_o;

  always #10 clk = ~clk;

  dsadc_seq #(.CLK_DIV(DIV), .SI_COUNTS(SI), .RI_MAX(RIMAX), .FRAME_COUNTS(FRAME)) uut (
    .clk(clk), .rst(rst), .cmp_i(cmp), .az_o(az_o), .si_o(si_o), .ri_o(ri_o),
    .ref_neg_o(ref_neg_o), .rd_bcd_o(rd_bcd_o), .rd_neg_o(rd_neg_o),
    .rd_over_o(rd_over_o), .rd_valid_o(rd_valid_o)
  );

  typedef struct {
    logic [15:0] bcd;
    bit          neg;
    bit          over;
    int          ri_clk;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  bit cfg_pos = 1;
  int cfg_n = 0;

  function automatic logic [15:0] to_bcd(int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Integrator model: holds the input sign, flips once the crossing count is due.
  int j = 0;
  always @(negedge clk) begin
    if (rst || !ri_o) j = 0;
    else j++;
    cmp = (ri_o && j > cfg_n * DIV) ? !cfg_pos : cfg_pos;
  end

  // Monitor / scoreboard
  logic [2:0] prev = 3'b100;
  int run = 0;
  bit first = 1;
  bit have_az = 0;
  int exp_az = 0;
  always @(negedge clk) begin
    logic [2:0] code;
    exp_t it;
    code = {az_o, si_o, ri_o};
    if (rst) begin
      prev = 3'b100; run = 0; first = 1; have_az = 0;
    end else begin
      if (rd_valid_o && !(prev == 3'b001 && code == 3'b100)) chk(0, 1, "R8 strobe outside end of reference phase");
      if (code == prev) run++;
      else begin
        if (prev == 3'b100 && code == 3'b010) begin
          if (first) chk(run + 1, (FRAME - SI - RIMAX) * DIV, "R9 first auto-zero length");
          else if (have_az) chk(run, exp_az, "R5 auto-zero fills the frame");
          first = 0;
        end else if (prev == 3'b010 && code == 3'b001) begin
          chk(run, SI * DIV, "R1 R3 signal integrate length");
          if (q.size() != 0) chk(ref_neg_o, q[0].neg, "R6 reference polarity");
        end else if (prev == 3'b001 && code == 3'b100) begin
          if (q.size() == 0) chk(0, 1, "R8 unexpected reading");
          else begin
            it = q.pop_front();
            chk(run, it.ri_clk, "R4 reference integrate length");
            chk(rd_valid_o, 1, "R8 valid on reference end");
            chk(rd_bcd_o, it.bcd, "R7 BCD reading");
            chk(rd_neg_o, it.neg, "R6 minus flag");
            chk(rd_over_o, it.over, "R10 overrange flag");
            exp_az = (FRAME - SI) * DIV - it.ri_clk;
            have_az = 1;
          end
        end else begin
          chk(code, 0, "R2 phase order");
        end
        run = 1;
        prev = code;
      end
    end
  end

  task automatic run_conv(int n, bit pos);
    exp_t e;
    cfg_pos = pos;
    cfg_n = n;
    if (n < RIMAX) begin
      e.bcd = to_bcd(n); e.over = 0; e.ri_clk = (n + 1) * DIV;
    end else begin
      e.bcd = to_bcd(RIMAX - 1); e.over = 1; e.ri_clk = RIMAX * DIV;
    end
    e.neg = !pos;
    q.push_back(e);
    do @(negedge clk); while (!si_o);
    do @(negedge clk); while (!az_o);
  endtask

  task automatic reset_checks();
    chk(az_o, 1, "R9 reset auto-zero");
    chk(si_o, 0, "R9 reset si");
    chk(ri_o, 0, "R9 reset ri");
    chk(ref_neg_o, 0, "R9 reset ref polarity");
    chk(rd_valid_o, 0, "R9 reset valid");
    chk(rd_bcd_o, 0, "R9 reset reading");
    chk(rd_over_o, 0, "R9 reset overrange");
    chk(rd_neg_o, 0, "R9 reset minus");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    reset_checks();
    rst <= 1'b0;
    run_conv(0, 1);
    run_conv(1, 0);
    run_conv(537, 1);
    run_conv(1000, 0);
    run_conv(1999, 1);
    run_conv(5000, 1);
    run_conv(5000, 0);
    run_conv(1234, 0);
    do @(negedge clk); while (!si_o);
    repeat (100) @(negedge clk);
    rst <= 1'b1;
    q.delete();
    repeat (3) @(negedge clk);
    reset_checks();
    rst <= 1'b0;
    run_conv(7, 1);
    repeat (10) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule